// File: doc/BRIEF.md
# Response Ring Writer with Coalesced Interrupt

This block takes responses returned by audio codecs and stores each one as an 8-byte entry in a circular response ring held in system memory. Each stored entry carries the 32-bit response word and an extra word that identifies the responding codec and whether the response was unsolicited. The block keeps the ring write pointer and counts the responses it has stored. It reports that count to the command fetch engine, which stops fetching once the count reaches the programmed threshold.

Interrupts are coalesced. The interrupt status bit is set when the stored-response count reaches a programmable threshold. It is also set when the command ring has drained, that is, when the command read and write pointers are equal. Software clears the status bit by writing a 1 to it. A clear that takes the bit from 1 to 0 resets the response count and produces a one-cycle pulse that restarts command fetching.

While the immediate-command busy flag is set, the next response bypasses the ring and is captured in an immediate response register instead. The response input is a valid/ready stream. `rsp_ready` is low only when a ring write is needed and the previous memory write is still waiting for `mem_req_ready`. In every other case, including immediate capture and the drop path, responses are accepted at once. The memory write port is a valid/ready request that holds its address and data stable until it is taken.

Top module: `resp_ring_writer`

## Requirements
- R1: A ring entry is written as one 64-bit request. Bits 31:0 hold the response word. Bits 63:32 hold the extra word: codec address in bits 3:0, bit 4 set when the response is unsolicited, all other bits zero.
- R2: The write pointer is incremented before each ring write, wrapping from 255 to 0. The entry address is `ring_base + 8 * new pointer`, and `wr_ptr` shows the new pointer after the write.
- R3: Each ring write increments `rsp_count` by one, wrapping modulo 256. The counter also counts while interrupts are disabled.
- R4: When a ring write brings `rsp_count` equal to `count_thresh` and `irq_en` is 1, `irq_sts` becomes 1.
- R5: When a ring write does not reach the threshold, `irq_sts` becomes 1 if `irq_en` is 1 and `cmd_rd_ptr == cmd_wr_ptr`. A write made while the command pointers differ and below the threshold leaves `irq_sts` at 0.
- R6: With `irq_en` at 0, no ring write sets `irq_sts`, even at the threshold or with the command ring empty.
- R7: With `dma_en` at 0 and busy clear, responses are accepted and dropped. No memory request is issued, and the pointer and count are unchanged.
- R8: A pointer write with `ptr_wr_data[15]` at 1 resets `wr_ptr` to 0. With bit 15 at 0 the write has no effect.
- R9: A status write with `sts_wr_data[0]` at 1 clears `irq_sts`. When that clear takes the bit from 1 to 0, `rsp_count` becomes 0 and `fetch_resume` pulses high for exactly one cycle. Writing 0 to bit 0 has no effect.
- R10: An immediate-control write sets busy from bit 0 and clears valid when bit 1 is 1. A response taken while busy is stored in `imm_resp`; busy goes to 0, valid to 1 and the codec address to `imm_status[7:4]`. No ring write takes place. `imm_status` is {address, 2'b00, valid, busy}.
- R11: While a memory request is pending (`mem_req_valid` high and `mem_req_ready` low), a response that needs a ring write sees `rsp_ready` low. The request address and data, the pointer and the count all stay unchanged.
- R12: After reset `wr_ptr`, `rsp_count`, `irq_sts`, `fetch_resume`, `mem_req_valid` and `imm_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Codec response present |
| rsp_ready | output | 1 | Response accepted this cycle when high with rsp_valid |
| rsp_data | input | 32 | Response word |
| rsp_unsol | input | 1 | Response is unsolicited |
| rsp_cad | input | 4 | Address of the responding codec |
| mem_req_valid | output | 1 | Ring entry write request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | AW | Byte address of the entry |
| mem_req_data | output | 64 | Entry: extra word in 63:32, response in 31:0 |
| ring_base | input | AW | Byte base address of the response ring |
| dma_en | input | 1 | Ring writes enabled |
| irq_en | input | 1 | Interrupt status may be set |
| count_thresh | input | CNT_W | Response count threshold |
| ptr_wr | input | 1 | Pointer register write strobe |
| ptr_wr_data | input | 16 | Pointer write data; bit 15 resets the pointer |
| sts_wr | input | 1 | Status register write strobe |
| sts_wr_data | input | 8 | Status write data; bit 0 is write-1-to-clear |
| imm_wr | input | 1 | Immediate-control write strobe |
| imm_wr_data | input | 2 | Bit 0 busy value, bit 1 clears valid |
| cmd_rd_ptr | input | PTR_W | Command ring read pointer |
| cmd_wr_ptr | input | PTR_W | Command ring write pointer |
| wr_ptr | output | PTR_W | Response ring write pointer |
| rsp_count | output | CNT_W | Responses stored since last clear |
| irq_sts | output | 1 | Coalesced interrupt status |
| fetch_resume | output | 1 | One-cycle pulse after the count is reset |
| imm_resp | output | 32 | Captured immediate response |
| imm_status | output | 8 | Immediate status: address, valid, busy |

## Verification
Several properties are checked on every cycle. The pointer and the pending request stay frozen while memory stalls. The pointer changes only on a ring write or a pointer reset. The status bit rises only from a ring write with interrupts enabled. A zero write to the status bit leaves it alone. The resume pulse follows a set status bit, and a clear always leaves the count at 0 or 1. Immediate capture always leaves busy clear and valid set, and valid only rises out of busy. The directed scenarios cover what those properties cannot express: the exact entry layout and addresses, the threshold count, pointer and counter wrap after 256 writes, the drop path, and back-pressure being released.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  localparam int WORD_W    = 32;
  localparam int CAD_W     = 4;
  localparam int UNSOL_BIT = 4;
  localparam int ENTRY_LG2 = 3;

  typedef struct packed {
    logic [WORD_W-1:0] extra;
    logic [WORD_W-1:0] resp;
  } ring_entry_t;
endpackage

// File: rtl/rrw_entry_fmt.sv
module rrw_entry_fmt
  import rrw_pkg::*;
(
  input  logic [WORD_W-1:0] resp,
  input  logic              unsol,
  input  logic [CAD_W-1:0]  cad,
  output ring_entry_t       entry
);
  always_comb begin
    entry.resp             = resp;
    entry.extra            = '0;
    entry.extra[CAD_W-1:0] = cad;
    entry.extra[UNSOL_BIT] = unsol;
  end
endmodule

// File: rtl/rrw_ptr_cnt.sv
module rrw_ptr_cnt #(
  parameter int PTR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             ptr_rst,
  input  logic             cnt_rst,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] slot_ptr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_after
);
  logic [PTR_W-1:0] ptr_q, ptr_base;
  logic [CNT_W-1:0] cnt_q, cnt_base;

  always_comb begin
    ptr_base    = ptr_rst ? '0 : ptr_q;
    slot_ptr    = ptr_base + 1'b1;
    cnt_base    = cnt_rst ? '0 : cnt_q;
    count_after = cnt_base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= push ? slot_ptr : ptr_base;
      cnt_q <= push ? count_after : cnt_base;
    end
  end

  assign wr_ptr = ptr_q;
  assign count  = cnt_q;

  assert_ptr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !ptr_rst) |=> $stable(wr_ptr));
  assert_cnt_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> (count <= CNT_W'(1)));
endmodule

// File: rtl/rrw_status.sv
module rrw_status (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic thresh_hit,
  input  logic ring_empty,
  input  logic irq_en,
  input  logic w1c_wr,
  input  logic w1c_bit,
  output logic irq_sts,
  output logic clr_hit,
  output logic fetch_resume
);
  logic set_ev, clr_req;

  always_comb begin
    set_ev  = push && irq_en && (thresh_hit || ring_empty);
    clr_req = w1c_wr && w1c_bit;
    clr_hit = clr_req && irq_sts;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_sts      <= 1'b0;
      fetch_resume <= 1'b0;
    end else begin
      irq_sts      <= set_ev || (irq_sts && !clr_req);
      fetch_resume <= clr_hit;
    end
  end

  assert_sts_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sts) |-> ($past(irq_en) && $past(push)));
  assert_resume_after_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_resume |-> $past(irq_sts));
  assert_zero_write_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_wr && !w1c_bit && !push) |=> (irq_sts == $past(irq_sts)));
endmodule

// File: rtl/rrw_imm.sv
module rrw_imm
  import rrw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [WORD_W-1:0] resp,
  input  logic [CAD_W-1:0]  cad,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_data,
  output logic              busy,
  output logic [WORD_W-1:0] imm_resp,
  output logic [7:0]        imm_status
);
  logic             valid_q;
  logic [CAD_W-1:0] cad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      valid_q  <= 1'b0;
      cad_q    <= '0;
      imm_resp <= '0;
    end else if (cap) begin
      busy     <= 1'b0;
      valid_q  <= 1'b1;
      cad_q    <= cad;
      imm_resp <= resp;
    end else if (ctl_wr) begin
      busy <= ctl_data[0];
      if (ctl_data[1]) valid_q <= 1'b0;
    end
  end

  assign imm_status = {cad_q, 2'b00, valid_q, busy};

  assert_capture_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (!busy && imm_status[1]));
  assert_valid_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imm_status[1]) |-> $past(busy));
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer
  import rrw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PTR_W = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic              rsp_unsol,
  input  logic [CAD_W-1:0]  rsp_cad,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  output logic [2*WORD_W-1:0] mem_req_data,
  input  logic [AW-1:0]     ring_base,
  input  logic              dma_en,
  input  logic              irq_en,
  input  logic [CNT_W-1:0]  count_thresh,
  input  logic              ptr_wr,
  input  logic [15:0]       ptr_wr_data,
  input  logic              sts_wr,
  input  logic [7:0]        sts_wr_data,
  input  logic              imm_wr,
  input  logic [1:0]        imm_wr_data,
  input  logic [PTR_W-1:0]  cmd_rd_ptr,
  input  logic [PTR_W-1:0]  cmd_wr_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [CNT_W-1:0]  rsp_count,
  output logic              irq_sts,
  output logic              fetch_resume,
  output logic [WORD_W-1:0] imm_resp,
  output logic [7:0]        imm_status
);
  localparam int PAD_W = AW - PTR_W - ENTRY_LG2;

  logic        imm_busy, accept, cap, push, pending;
  logic        ptr_rst, clr_hit, thresh_hit, ring_empty;
  logic [PTR_W-1:0] slot_ptr;
  logic [CNT_W-1:0] count_after;
  ring_entry_t entry;
  logic        unused_bits;

  assign unused_bits = ^{ptr_wr_data[14:0], sts_wr_data[7:1]};

  always_comb begin
    pending    = mem_req_valid && !mem_req_ready;
    rsp_ready  = imm_busy || !dma_en || !pending;
    accept     = rsp_valid && rsp_ready;
    cap        = accept && imm_busy;
    push       = accept && !imm_busy && dma_en;
    ptr_rst    = ptr_wr && ptr_wr_data[15];
    ring_empty = (cmd_rd_ptr == cmd_wr_ptr);
    thresh_hit = (count_after == count_thresh);
  end

  rrw_entry_fmt u_fmt (
    .resp  (rsp_data),
    .unsol (rsp_unsol),
    .cad   (rsp_cad),
    .entry (entry)
  );

  rrw_ptr_cnt #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .ptr_rst     (ptr_rst),
    .cnt_rst     (clr_hit),
    .wr_ptr      (wr_ptr),
    .slot_ptr    (slot_ptr),
    .count       (rsp_count),
    .count_after (count_after)
  );

  rrw_status u_sts (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (push),
    .thresh_hit   (thresh_hit),
    .ring_empty   (ring_empty),
    .irq_en       (irq_en),
    .w1c_wr       (sts_wr),
    .w1c_bit      (sts_wr_data[0]),
    .irq_sts      (irq_sts),
    .clr_hit      (clr_hit),
    .fetch_resume (fetch_resume)
  );

  rrw_imm u_imm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (cap),
    .resp       (rsp_data),
    .cad        (rsp_cad),
    .ctl_wr     (imm_wr),
    .ctl_data   (imm_wr_data),
    .busy       (imm_busy),
    .imm_resp   (imm_resp),
    .imm_status (imm_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_data  <= '0;
    end else if (push) begin
      mem_req_valid <= 1'b1;
      mem_req_addr  <= ring_base + {{PAD_W{1'b0}}, slot_ptr, {ENTRY_LG2{1'b0}}};
      mem_req_data  <= entry;
    end else if (mem_req_ready) begin
      mem_req_valid <= 1'b0;
    end
  end

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));
  assert_ptr_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !ptr_wr) |=> $stable(wr_ptr));
  assert_drop_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !mem_req_valid) |=> !mem_req_valid);
endmodule

// File: tb/test_resp_ring_writer.sv
`timescale 1ns/100ps
module test_resp_ring_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsp_valid = 0, rsp_unsol = 0, mem_req_ready = 1;
  logic [31:0] rsp_data = '0;
  logic [3:0]  rsp_cad = '0;
  logic rsp_ready, mem_req_valid;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_data;
  logic [31:0] ring_base = 32'h0001_0000;
  logic dma_en = 1, irq_en = 0;
  logic [7:0] count_thresh = 8'd200;
  logic ptr_wr = 0, sts_wr = 0, imm_wr = 0;
  logic [15:0] ptr_wr_data = '0;
  logic [7:0]  sts_wr_data = '0;
  logic [1:0]  imm_wr_data = '0;
  logic [7:0]  cmd_rd_ptr = 8'd0, cmd_wr_ptr = 8'd1;
  logic [7:0]  wr_ptr, rsp_count, imm_status;
  logic irq_sts, fetch_resume;
  logic [31:0] imm_resp;

  int tests = 0;
  int fails = 0;
  localparam logic [31:0] BASE = 32'h0001_0000;

  always #2.5 clk = ~clk;

  resp_ring_writer i_resp_ring_writer (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_unsol(rsp_unsol), .rsp_cad(rsp_cad),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .ring_base(ring_base), .dma_en(dma_en), .irq_en(irq_en),
    .count_thresh(count_thresh), .ptr_wr(ptr_wr), .ptr_wr_data(ptr_wr_data),
    .sts_wr(sts_wr), .sts_wr_data(sts_wr_data), .imm_wr(imm_wr),
    .imm_wr_data(imm_wr_data), .cmd_rd_ptr(cmd_rd_ptr), .cmd_wr_ptr(cmd_wr_ptr),
    .wr_ptr(wr_ptr), .rsp_count(rsp_count), .irq_sts(irq_sts),
    .fetch_resume(fetch_resume), .imm_resp(imm_resp), .imm_status(imm_status)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; rsp_valid = 0; mem_req_ready = 1; dma_en = 1; irq_en = 0;
    count_thresh = 8'd200; cmd_rd_ptr = 8'd0; cmd_wr_ptr = 8'd1;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input logic [31:0] d, input logic u, input logic [3:0] c);
    rsp_valid = 1; rsp_data = d; rsp_unsol = u; rsp_cad = c;
    #1;
    while (!rsp_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic wr_ptr_reg(input logic [15:0] d);
    ptr_wr = 1; ptr_wr_data = d; @(negedge clk); ptr_wr = 0;
  endtask

  task automatic wr_sts(input logic [7:0] d);
    sts_wr = 1; sts_wr_data = d; @(negedge clk); sts_wr = 0;
  endtask

  task automatic wr_imm(input logic [1:0] d);
    imm_wr = 1; imm_wr_data = d; @(negedge clk); imm_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 wr_ptr", 64'(wr_ptr), 64'd0);
    chk("R12 rsp_count", 64'(rsp_count), 64'd0);
    chk("R12 irq_sts", 64'(irq_sts), 64'd0);
    chk("R12 fetch_resume", 64'(fetch_resume), 64'd0);
    chk("R12 mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R12 imm_status", 64'(imm_status), 64'd0);
  endtask

  task automatic t_format();
    do_reset();
    send(32'hCAFE_0001, 1'b0, 4'h3);
    chk("R1 solicited entry", mem_req_data, {32'h0000_0003, 32'hCAFE_0001});
    chk("R2 first addr", 64'(mem_req_addr), 64'(BASE + 32'd8));
    chk("R2 ptr", 64'(wr_ptr), 64'd1);
    chk("R3 count", 64'(rsp_count), 64'd1);
    send(32'h1234_5678, 1'b1, 4'hA);
    chk("R1 unsolicited entry", mem_req_data, {32'h0000_001A, 32'h1234_5678});
    chk("R2 second addr", 64'(mem_req_addr), 64'(BASE + 32'd16));
    chk("R3 count 2", 64'(rsp_count), 64'd2);
  endtask

  task automatic t_threshold_and_clear();
    do_reset();
    irq_en = 1; count_thresh = 8'd3;
    send(32'h1, 1'b0, 4'h0);
    chk("R5 not empty no irq", 64'(irq_sts), 64'd0);
    send(32'h2, 1'b0, 4'h0);
    chk("R4 below thresh", 64'(irq_sts), 64'd0);
    send(32'h3, 1'b0, 4'h0);
    chk("R4 at thresh", 64'(irq_sts), 64'd1);
    wr_sts(8'h00);
    chk("R9 zero write sts", 64'(irq_sts), 64'd1);
    chk("R9 zero write count", 64'(rsp_count), 64'd3);
    chk("R9 zero write no resume", 64'(fetch_resume), 64'd0);
    wr_sts(8'h01);
    chk("R9 cleared", 64'(irq_sts), 64'd0);
    chk("R9 count reset", 64'(rsp_count), 64'd0);
    chk("R9 resume pulse", 64'(fetch_resume), 64'd1);
    @(negedge clk);
    chk("R9 resume one cycle", 64'(fetch_resume), 64'd0);
    send(32'h4, 1'b0, 4'h0);
    chk("R3 count after clear", 64'(rsp_count), 64'd1);
  endtask

  task automatic t_irq_off();
    do_reset();
    irq_en = 0; count_thresh = 8'd1; cmd_rd_ptr = 8'd9; cmd_wr_ptr = 8'd9;
    send(32'h5, 1'b0, 4'h1);
    chk("R6 no irq when disabled", 64'(irq_sts), 64'd0);
    chk("R3 counts when disabled", 64'(rsp_count), 64'd1);
  endtask

  task automatic t_ring_empty();
    do_reset();
    irq_en = 1; count_thresh = 8'd50; cmd_rd_ptr = 8'd4; cmd_wr_ptr = 8'd4;
    send(32'h6, 1'b0, 4'h2);
    chk("R5 ring empty irq", 64'(irq_sts), 64'd1);
  endtask

  task automatic t_dma_off();
    do_reset();
    dma_en = 0;
    #1;
    chk("R7 ready while dropping", 64'(rsp_ready), 64'd1);
    send(32'h7, 1'b0, 4'h2);
    chk("R7 no request", 64'(mem_req_valid), 64'd0);
    chk("R7 ptr kept", 64'(wr_ptr), 64'd0);
    chk("R7 count kept", 64'(rsp_count), 64'd0);
  endtask

  task automatic t_ptr_reset_wrap();
    do_reset();
    for (int i = 0; i < 3; i++) send(32'(i), 1'b0, 4'h0);
    wr_ptr_reg(16'h0005);
    chk("R8 bit15 clear ignored", 64'(wr_ptr), 64'd3);
    wr_ptr_reg(16'h8000);
    chk("R8 pointer reset", 64'(wr_ptr), 64'd0);
    send(32'hAA, 1'b0, 4'h0);
    chk("R8 addr after reset", 64'(mem_req_addr), 64'(BASE + 32'd8));
    wr_ptr_reg(16'h8000);
    for (int i = 0; i < 255; i++) send(32'(i), 1'b0, 4'h0);
    chk("R2 ptr at top", 64'(wr_ptr), 64'd255);
    send(32'hBB, 1'b0, 4'h0);
    chk("R2 ptr wrapped", 64'(wr_ptr), 64'd0);
    chk("R2 addr wrapped", 64'(mem_req_addr), 64'(BASE));
    chk("R3 count wrapped", 64'(rsp_count), 64'd4);
  endtask

  task automatic t_immediate();
    do_reset();
    wr_imm(2'b01);
    chk("R10 busy set", 64'(imm_status), 64'h01);
    send(32'hDEAD_BEEF, 1'b0, 4'h5);
    chk("R10 captured", 64'(imm_resp), 64'hDEAD_BEEF);
    chk("R10 status", 64'(imm_status), 64'h52);
    chk("R10 no ring write", 64'(mem_req_valid), 64'd0);
    chk("R10 ptr kept", 64'(wr_ptr), 64'd0);
    wr_imm(2'b10);
    chk("R10 valid cleared", 64'(imm_status), 64'h50);
    send(32'h9, 1'b0, 4'h5);
    chk("R10 back to ring", 64'(wr_ptr), 64'd1);
  endtask

  task automatic t_backpressure();
    do_reset();
    mem_req_ready = 0;
    send(32'hA0, 1'b0, 4'h1);
    rsp_valid = 1; rsp_data = 32'hB0; rsp_cad = 4'h2; rsp_unsol = 0;
    #1;
    chk("R11 ready low", 64'(rsp_ready), 64'd0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    #1;
    chk("R11 ptr held", 64'(wr_ptr), 64'd1);
    chk("R11 addr held", 64'(mem_req_addr), 64'(BASE + 32'd8));
    chk("R11 data held", mem_req_data, {32'h1, 32'hA0});
    chk("R11 count held", 64'(rsp_count), 64'd1);
    mem_req_ready = 1;
    #1;
    chk("R11 ready released", 64'(rsp_ready), 64'd1);
    @(negedge clk);
    rsp_valid = 0;
    chk("R11 second ptr", 64'(wr_ptr), 64'd2);
    chk("R11 second addr", 64'(mem_req_addr), 64'(BASE + 32'd16));
  endtask

  initial begin
    t_reset();
    t_format();
    t_threshold_and_clear();
    t_irq_off();
    t_ring_empty();
    t_dma_off();
    t_ptr_reset_wrap();
    t_immediate();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule